// File: doc/BRIEF.md
# Timer-Synchronised Audio Sample Register

This block stages audio samples for two voice channels on their way to a PWM or DAC modulator. Software sends each 12-bit sample as two byte writes. The low byte carries the four least significant sample bits in its upper nibble. The high byte carries the eight most significant bits. The low byte is held in a per-channel shadow. The sample is assembled only when the high byte arrives, so a half-written value never reaches the modulator.

Channel 0 can pass a completed sample to its output at once, or hold it until the next timer B event. Channel 1 always waits for that event. Holding a sample for the event gives an exact output sample rate, however irregular the software writes are. A second control input picks the output mode. In separate mode each channel drives its own output. In mix mode the unsigned saturating sum of both staged samples drives output 0, and output 1 rests at mid-scale.

Top module: `audio_sample_stage`

## Requirements
- R1: After reset both staged samples are mid-scale 0x800, nothing is pending, and both outputs read 0x800 in separate mode.
- R2: `wr_sel` encodes the target as channel*2 + half. The values are 0 for ch0 low, 1 for ch0 high, 2 for ch1 low and 3 for ch1 high. A high write builds the sample as {wr_data[7:0], shadow[3:0]}, where the shadow holds bits 7:4 of that channel's last low write.
- R3: Bits 3:0 of a low-byte write are ignored and never affect any sample.
- R4: A low-byte write alone never changes either output.
- R5: With `ch0_on_tick` = 0, a ch0 high write shows on the channel 0 output in the cycle after its clock edge, and it cancels any ch0 sample still pending.
- R6: With `ch0_on_tick` = 1, a ch0 high write only becomes pending. The output holds its value until a `tick_b` edge, and the sample shows after that edge.
- R7: A ch1 high write always becomes pending, and it moves to the channel 1 output only on `tick_b`.
- R8: A later high write to a channel replaces its pending sample, so only the most recent one is transferred.
- R9: A `tick_b` while a channel has nothing pending leaves that channel's output unchanged.
- R10: With `mix_en` = 1, `voice_out0` is min(s0 + s1, 0xFFF), taken unsigned, and `voice_out1` is 0x800. With `mix_en` = 0, each output shows its own staged sample.
- R11: When `tick_b` and a high write to a waiting channel fall in the same cycle, the previously pending sample moves to the output and the new sample becomes pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | 2 | Write target: channel*2 + half (0 is low, 1 is high) |
| wr_data | input | 8 | Byte being written |
| tick_b | input | 1 | One-cycle timer B event |
| ch0_on_tick | input | 1 | 1: channel 0 waits for tick_b; 0: channel 0 updates at once |
| mix_en | input | 1 | 1: mix mode; 0: separate mode |
| voice_out0 | output | 12 | Channel 0 sample, or the mixed sum |
| voice_out1 | output | 12 | Channel 1 sample, or mid-scale in mix mode |

## Verification
Three properties are checked on every cycle: a waiting channel holds steady between ticks, a tick moves exactly the sample that was pending, and an idle tick or a lone low write leaves the staged value alone. The mix output is also checked every cycle, for never falling below either operand and for resting output 1 at mid-scale. Only the bench scenarios can show the bit packing with ignored reserved bits, the latest-write-wins replacement, and the ordering when a write meets a tick. They also show the exact clamped and unclamped sums, because these depend on values carried across several writes.

// File: rtl/asr_pkg.sv
package asr_pkg;
  // which byte of a sample a write targets; value is the low bit of wr_sel
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;
endpackage

// File: rtl/sample_assembler.sv
module sample_assembler #(
  parameter int SAMPLE_W = 12,
  parameter int BYTE_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lo_wr,
  input  logic                hi_wr,
  input  logic [BYTE_W-1:0]   wr_data,
  output logic [SAMPLE_W-1:0] built_sample
);
  localparam int LOW_W = SAMPLE_W - BYTE_W;

  logic [LOW_W-1:0] shadow_q;

  // only the upper nibble of the low byte is kept; the rest is reserved
  always_ff @(posedge clk) begin
    if (!rst_n)     shadow_q <= '0;
    else if (lo_wr) shadow_q <= wr_data[BYTE_W-1 -: LOW_W];
  end

  assign built_sample = {wr_data, shadow_q};

  // R4: the shadow only moves on a low write
  p_shadow_only_on_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_wr |=> $stable(shadow_q));

  // hi_wr is part of the interface; the assembled value is used on that strobe
  p_no_dual_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(lo_wr && hi_wr));
endmodule

// File: rtl/sample_stage.sv
module sample_stage #(
  parameter int              SAMPLE_W = 12,
  parameter logic [SAMPLE_W-1:0] MID  = 12'h800
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hi_wr,
  input  logic [SAMPLE_W-1:0] new_sample,
  input  logic                on_tick,
  input  logic                tick,
  output logic [SAMPLE_W-1:0] staged,
  output logic                pend_valid
);
  logic [SAMPLE_W-1:0] pend_q, stage_q;
  logic                pend_v_q;
  logic                take_pending;  // named event: tick moves the pending sample
  logic                direct_load;   // named event: immediate-mode write

  assign take_pending = tick && pend_v_q;
  assign direct_load  = hi_wr && !on_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= MID;
      pend_v_q <= 1'b0;
      stage_q  <= MID;
    end else begin
      if (take_pending) begin
        stage_q  <= pend_q;
        pend_v_q <= 1'b0;
      end
      // a write in the same cycle is ordered after the transfer
      if (hi_wr) begin
        if (on_tick) begin
          pend_q   <= new_sample;
          pend_v_q <= 1'b1;
        end else begin
          stage_q  <= new_sample;
          pend_v_q <= 1'b0;
        end
      end
    end
  end

  assign staged     = stage_q;
  assign pend_valid = pend_v_q;

  // R6: a waiting channel is frozen between ticks
  p_hold_between_ticks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (on_tick && !tick) |=> $stable(stage_q));

  // R11: a tick moves exactly the older pending sample
  p_tick_takes_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (take_pending && !direct_load) |=> (stage_q == $past(pend_q)));

  // R9: an idle tick changes nothing
  p_idle_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pend_v_q && !hi_wr) |=> $stable(stage_q));

  // R5: an immediate write lands next cycle and clears any pending sample
  p_direct_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    direct_load |=> (stage_q == $past(new_sample)) && !pend_v_q);
endmodule

// File: rtl/output_mixer.sv
module output_mixer #(
  parameter int                  SAMPLE_W = 12,
  parameter logic [SAMPLE_W-1:0] MID      = 12'h800
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mix_en,
  input  logic [SAMPLE_W-1:0] s0,
  input  logic [SAMPLE_W-1:0] s1,
  output logic [SAMPLE_W-1:0] out0,
  output logic [SAMPLE_W-1:0] out1
);
  function automatic logic [SAMPLE_W-1:0] clamp_sum(input logic [SAMPLE_W-1:0] a,
                                                    input logic [SAMPLE_W-1:0] b);
    logic [SAMPLE_W:0] wide;
    wide = {1'b0, a} + {1'b0, b};
    return wide[SAMPLE_W] ? {SAMPLE_W{1'b1}} : wide[SAMPLE_W-1:0];
  endfunction

  logic [SAMPLE_W-1:0] mixed;
  assign mixed = clamp_sum(s0, s1);

  always_comb begin
    if (mix_en) begin
      out0 = mixed;
      out1 = MID;
    end else begin
      out0 = s0;
      out1 = s1;
    end
  end

  // R10: the mixed output never wraps below either operand, and output 1 rests
  p_mix_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mix_en |-> (out0 >= s0) && (out0 >= s1) && (out1 == MID));
endmodule

// File: rtl/audio_sample_stage.sv
module audio_sample_stage #(
  parameter int SAMPLE_W = 12,
  parameter int BYTE_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic                tick_b,
  input  logic                ch0_on_tick,
  input  logic                mix_en,
  output logic [SAMPLE_W-1:0] voice_out0,
  output logic [SAMPLE_W-1:0] voice_out1
);
  import asr_pkg::*;

  localparam int                  NUM_CH = 2;
  localparam logic [SAMPLE_W-1:0] MID    = SAMPLE_W'(1) << (SAMPLE_W - 1);

  logic [SAMPLE_W-1:0] staged [NUM_CH];
  logic [NUM_CH-1:0]   ch_lo_wr, ch_hi_wr, ch_pending;

  half_e wr_half;
  assign wr_half = half_e'(wr_sel[0]);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [SAMPLE_W-1:0] built;
    logic                waits;

    assign ch_lo_wr[c] = wr_en && (wr_sel[1] == 1'(c)) && (wr_half == HALF_LO);
    assign ch_hi_wr[c] = wr_en && (wr_sel[1] == 1'(c)) && (wr_half == HALF_HI);
    // channel 0 chooses its transfer; channel 1 always waits for the event
    assign waits       = (c == 0) ? ch0_on_tick : 1'b1;

    sample_assembler #(.SAMPLE_W(SAMPLE_W), .BYTE_W(BYTE_W)) i_asm (
      .clk          (clk),
      .rst_n        (rst_n),
      .lo_wr        (ch_lo_wr[c]),
      .hi_wr        (ch_hi_wr[c]),
      .wr_data      (wr_data),
      .built_sample (built)
    );

    sample_stage #(.SAMPLE_W(SAMPLE_W), .MID(MID)) i_stage (
      .clk        (clk),
      .rst_n      (rst_n),
      .hi_wr      (ch_hi_wr[c]),
      .new_sample (built),
      .on_tick    (waits),
      .tick       (tick_b),
      .staged     (staged[c]),
      .pend_valid (ch_pending[c])
    );

    // R4: a low write alone, with no tick, leaves the staged value alone
    p_low_write_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_lo_wr[c] && !tick_b) |=> $stable(staged[c]));
  end

  output_mixer #(.SAMPLE_W(SAMPLE_W), .MID(MID)) i_mix (
    .clk    (clk),
    .rst_n  (rst_n),
    .mix_en (mix_en),
    .s0     (staged[0]),
    .s1     (staged[1]),
    .out0   (voice_out0),
    .out1   (voice_out1)
  );

  // R7: channel 1 only gains a pending sample through a high write
  p_ch1_pending_from_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ch_pending[1]) |-> $past(ch_hi_wr[1]));
endmodule

// File: tb/test_audio_sample_stage.sv
module test_audio_sample_stage;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;
  logic        tick_b = 1'b0;
  logic        ch0_on_tick = 1'b0;
  logic        mix_en = 1'b0;
  logic [11:0] voice_out0, voice_out1;

  always #5 clk = ~clk;

  audio_sample_stage i_audio_sample_stage (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tick_b(tick_b), .ch0_on_tick(ch0_on_tick), .mix_en(mix_en),
    .voice_out0(voice_out0), .voice_out1(voice_out1)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // reference model state
  logic [11:0] ms0 = 12'h800, ms1 = 12'h800, mp0 = 12'h800, mp1 = 12'h800;
  logic        mv0 = 0, mv1 = 0;
  logic [3:0]  sh0 = 0, sh1 = 0;

  logic [23:0] exp_q[$];
  string       tag_q[$];
  event        chk_ev;

  function automatic logic [11:0] clip_add(logic [11:0] a, logic [11:0] b);
    int s;
    s = int'(a) + int'(b);
    return (s > 4095) ? 12'hFFF : 12'(s);
  endfunction

  task automatic push_expect(string tag);
    logic [11:0] e0, e1;
    if (mix_en) begin
      e0 = clip_add(ms0, ms1);
      e1 = 12'h800;
    end else begin
      e0 = ms0;
      e1 = ms1;
    end
    exp_q.push_back({e0, e1});
    tag_q.push_back(tag);
    -> chk_ev;
  endtask

  task automatic step(bit we, logic [1:0] sel, logic [7:0] d, bit tk, string tag);
    logic [11:0] nw;
    @(negedge clk);
    wr_en = we; wr_sel = sel; wr_data = d; tick_b = tk;
    @(posedge clk);
    #1;
    if (tk) begin
      if (mv0) begin ms0 = mp0; mv0 = 0; end
      if (mv1) begin ms1 = mp1; mv1 = 0; end
    end
    if (we) begin
      case (sel)
        2'd0: sh0 = d[7:4];
        2'd1: begin
          nw = {d, sh0};
          if (ch0_on_tick) begin mp0 = nw; mv0 = 1; end
          else begin ms0 = nw; mv0 = 0; end
        end
        2'd2: sh1 = d[7:4];
        default: begin mp1 = {d, sh1}; mv1 = 1; end
      endcase
    end
    wr_en = 0; tick_b = 0;
    push_expect(tag);
  endtask

  // monitor: pops expectations as results appear
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        logic [23:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        compared++;
        if ({voice_out0, voice_out1} !== e) begin
          mismatched++;
          $display("FAIL %s: out0=%h out1=%h expected out0=%h out1=%h",
                   t, voice_out0, voice_out1, e[23:12], e[11:0]);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    push_expect("R1 reset mid-scale");

    step(1, 2'd0, 8'hA5, 0, "R4 low write alone");
    step(1, 2'd1, 8'h3C, 0, "R2 R5 immediate ch0 packing");
    step(1, 2'd0, 8'h5F, 0, "R3 R4 reserved bits low write");
    step(1, 2'd1, 8'h12, 0, "R3 reserved bits ignored");
    step(1, 2'd2, 8'h70, 0, "R4 ch1 low write");
    step(1, 2'd3, 8'h9B, 0, "R7 ch1 waits for tick");
    step(0, 2'd0, 8'h00, 1, "R7 ch1 moves on tick");

    @(negedge clk); ch0_on_tick = 1;
    step(1, 2'd1, 8'h44, 0, "R6 ch0 held pending");
    step(0, 2'd0, 8'h00, 0, "R6 ch0 still held");
    step(0, 2'd0, 8'h00, 1, "R6 ch0 moves on tick");
    step(1, 2'd1, 8'h11, 0, "R8 first pending");
    step(1, 2'd1, 8'h22, 0, "R8 replaced pending");
    step(0, 2'd0, 8'h00, 1, "R8 latest transferred");
    step(0, 2'd0, 8'h00, 1, "R9 idle tick");
    step(1, 2'd1, 8'h66, 0, "R11 pending set");
    step(1, 2'd1, 8'h77, 1, "R11 write meets tick");
    step(0, 2'd0, 8'h00, 1, "R11 newer moves next tick");

    @(negedge clk); mix_en = 1; ch0_on_tick = 0;
    step(0, 2'd0, 8'h00, 0, "R10 mix saturates");
    step(1, 2'd1, 8'h01, 0, "R10 mix unclamped sum");
    @(negedge clk); mix_en = 0;
    step(0, 2'd0, 8'h00, 0, "R10 back to separate");
    step(1, 2'd1, 8'hF0, 0, "R5 immediate after pending");

    repeat (3) @(posedge clk);
    #1;
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule